// File: doc/BRIEF.md
# Paged Two-Wire Management Register Slave

This block sits inside a pluggable optical module and lets a host reach the module's management byte space over a two-wire serial bus. The space has 256 offsets. Offsets 0 to 127 form a fixed lower region. Offsets 128 to 255 form a window onto one of several 128-byte upper pages. The host picks the page by writing a page-select byte in the lower region. A byte pointer follows the host's accesses and advances by one after every byte.

The block answers on one fixed 7-bit bus address, and only while an active-low select input is held low. Several modules can therefore share one bus. The serial clock and data lines are sampled with the system clock, so the block has a single clock domain. The data line is only ever pulled low and is never driven high.

Two control bytes are held in dedicated registers and drive module outputs: one holds a per-lane transmitter disable and one holds a per-lane receiver squelch disable. Every read of a lower-region byte produces a one-cycle strobe with the byte offset. A status block can use this strobe to clear latched flags when they are read.

Top module: `twi_mgmt_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x50 (0xA0 with the write bit). Any other address gets no acknowledge, and the transfer that follows changes no byte.
- R2: While `mod_sel_n` is high, the slave gives no acknowledge to its own address, and writes sent in that transfer change no byte.
- R3: In a write transfer, the first data byte loads the byte pointer and each later byte is stored at the pointer, which then advances by one. A read transfer returns the byte at the pointer, and the pointer advances after each byte.
- R4: Offsets 0 to 127 return the same contents whichever page is selected.
- R5: Offset 127 is the page-select byte. It stores the low 2 bits of a written value and reads back with bits 7:2 as 0. Offsets 128 to 255 reach offset minus 128 of the selected page (pages 0 to 3), and each page keeps its own contents.
- R6: When the pointer advances from 255 it wraps to 128, so it stays inside the selected upper page. This applies to both reads and writes.
- R7: `tx_dis[k]` equals bit k of lower offset 86 (lane 1 is bit 0). The byte reads back as it was written.
- R8: `rx_sqdis[k]` equals bit 4+k of offset 240 in page 3. A write to offset 240 in any other page leaves `rx_sqdis` unchanged.
- R9: Reset returns `tx_dis`, `rx_sqdis` and the page select to 0 and releases the data line.
- R10: Each byte read from offsets 0 to 127 raises `rd_stb` for exactly one cycle, with `rd_addr` holding the offset. Reads from the upper window raise no strobe.
- R11: `sda_oe` is asserted only during an acknowledge slot or a read data bit, and is never asserted while the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| mod_sel_n | input | 1 | Active-low module select |
| sda_oe | output | 1 | Pull the data line low when 1 |
| tx_dis | output | NUM_CH | Per-lane transmitter disable |
| rx_sqdis | output | NUM_CH | Per-lane receiver squelch disable |
| rd_stb | output | 1 | One-cycle pulse for each lower-region byte read |
| rd_addr | output | 7 | Offset of the lower-region byte that was read |

## Verification
The bench builds the block with its default parameters: four upper pages, bus address 0x50, four lanes and a two-stage synchronizer. Each serial bit lasts 16 system clocks, so the synchronizer latency fits well within half a bit and a full paged transfer takes under a thousand cycles. With these values the bench can exercise every page, the page-3 squelch byte, the 255-to-128 wrap in both directions and the select line in a short run. The same traffic is replayed against the wrong address and with the slave deselected.

// File: rtl/twi_mgmt_pkg.sv
package twi_mgmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,  // waiting for a start condition
    ST_ADDR,  // shifting in the address byte
    ST_AACK,  // driving the address acknowledge
    ST_WR,    // shifting in a write byte
    ST_WACK,  // driving the write acknowledge
    ST_RD,    // shifting out a read byte
    ST_MACK   // sampling the host's acknowledge
  } twi_st_e;

  localparam int          PAGE_BYTES   = 128;
  localparam logic [7:0]  PAGE_SEL_OFS = 8'd127;

  // The pointer stays inside the upper window once it has reached it.
  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return (p == 8'hFF) ? 8'h80 : p + 8'd1;
  endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, cur, prev;
  assign raw = {scl_i, sda_i};

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_line
      logic [STAGES:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-1:0], raw[g]};
      end
      assign cur[g]  = pipe[STAGES-1];
      assign prev[g] = pipe[STAGES];
    end
  endgenerate

  assign sda_s     = cur[0];
  assign scl_rise  = cur[1] & ~prev[1];
  assign scl_fall  = ~cur[1] & prev[1];
  assign start_det = cur[1] & prev[1] & prev[0] & ~cur[0];
  assign stop_det  = cur[1] & prev[1] & ~prev[0] & cur[0];

endmodule

// File: rtl/twi_mgmt_regs.sv
module twi_mgmt_regs
  import twi_mgmt_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int NUM_CH     = 4,
  parameter int TXDIS_OFS  = 86,
  parameter int SQDIS_PAGE = 3,
  parameter int SQDIS_OFS  = 240,
  parameter int SQDIS_LSB  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [NUM_CH-1:0] tx_dis,
  output logic [NUM_CH-1:0] rx_sqdis
);
  localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int DEPTH  = (NUM_PAGES + 1) * PAGE_BYTES;
  localparam int IDX_W  = $clog2(DEPTH);

  logic [7:0]        mem [DEPTH];
  logic [PAGE_W-1:0] page_q;
  logic [7:0]        txd_q, sqd_q;
  logic [IDX_W-1:0]  widx, ridx;

  function automatic logic [IDX_W-1:0] map_idx(input logic [7:0] a, input logic [PAGE_W-1:0] pg);
    if (a[7]) return IDX_W'((int'(pg) + 1) * PAGE_BYTES + int'(a[6:0]));
    else      return IDX_W'(a[6:0]);
  endfunction

  function automatic logic is_sq(input logic [7:0] a, input logic [PAGE_W-1:0] pg);
    return (a == 8'(SQDIS_OFS)) && (pg == PAGE_W'(SQDIS_PAGE));
  endfunction

  assign widx = map_idx(wr_addr, page_q);
  assign ridx = map_idx(rd_addr, page_q);

  // Plain storage without reset, so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[widx] <= wr_data;
  end

  // Volatile control bytes with reset defaults.
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      txd_q  <= '0;
      sqd_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == PAGE_SEL_OFS)  page_q <= wr_data[PAGE_W-1:0];
      if (wr_addr == 8'(TXDIS_OFS)) txd_q  <= wr_data;
      if (is_sq(wr_addr, page_q))   sqd_q  <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr == PAGE_SEL_OFS)       rd_data = {{(8-PAGE_W){1'b0}}, page_q};
    else if (rd_addr == 8'(TXDIS_OFS)) rd_data = txd_q;
    else if (is_sq(rd_addr, page_q))   rd_data = sqd_q;
    else                               rd_data = mem[ridx];
  end

  assign tx_dis   = txd_q[NUM_CH-1:0];
  assign rx_sqdis = sqd_q[SQDIS_LSB +: NUM_CH];

endmodule

// File: rtl/twi_mgmt_slave.sv
module twi_mgmt_slave
  import twi_mgmt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         NUM_PAGES   = 4,
  parameter int         NUM_CH      = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              mod_sel_n,
  output logic              sda_oe,
  output logic [NUM_CH-1:0] tx_dis,
  output logic [NUM_CH-1:0] rx_sqdis,
  output logic              rd_stb,
  output logic [6:0]        rd_addr
);
  localparam int BITS = 8;

  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  twi_st_e    st;
  logic [3:0] cnt;
  logic [7:0] sh, txsh, ptr, wr_addr, wr_data, mem_rd;
  logic       rw, first, nack, wr_en;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_mgmt_regs #(.NUM_PAGES(NUM_PAGES), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(mem_rd), .tx_dis(tx_dis), .rx_sqdis(rx_sqdis)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      txsh    <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      first   <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_stb  <= 1'b0;
      rd_addr <= '0;
    end else begin
      wr_en  <= 1'b0;
      rd_stb <= 1'b0;
      if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        first  <= 1'b1;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'(BITS)) begin
              if (st == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR && !mod_sel_n) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  st     <= ST_AACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_WACK;
                if (first) begin
                  ptr   <= sh;
                  first <= 1'b0;
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr_next(ptr);
                end
              end
            end
          end
          ST_AACK, ST_WACK, ST_MACK: begin
            if (scl_rise && st == ST_MACK) nack <= sda_s;
            if (scl_fall) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              if (st == ST_WACK || (st == ST_AACK && !rw)) begin
                st <= ST_WR;
              end else if (st == ST_MACK && nack) begin
                st <= ST_IDLE;
              end else begin
                st      <= ST_RD;
                txsh    <= mem_rd;
                sda_oe  <= ~mem_rd[7];
                rd_stb  <= ~ptr[7];
                rd_addr <= ptr[6:0];
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'(BITS)) begin
                sda_oe <= 1'b0;
                ptr    <= ptr_next(ptr);
                st     <= ST_MACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twi_mgmt_checker.sv
module twi_mgmt_checker
  import twi_mgmt_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mod_sel_n,
  input logic              sda_oe,
  input logic              rd_stb,
  input logic              wr_en,
  input twi_st_e           st,
  input logic [NUM_CH-1:0] tx_dis,
  input logic [NUM_CH-1:0] rx_sqdis
);

  AST_NO_ACK_DESEL: assert property (@(posedge clk) disable iff (rst)
    (st == ST_AACK && $past(st) == ST_ADDR) |-> !$past(mod_sel_n)); // R2

  AST_TXDIS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst)) |-> $stable(tx_dis)); // R7

  AST_SQDIS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst)) |-> $stable(rx_sqdis)); // R8

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb); // R10

  AST_SDA_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe); // R11

endmodule

bind twi_mgmt_slave twi_mgmt_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .mod_sel_n(mod_sel_n), .sda_oe(sda_oe),
  .rd_stb(rd_stb), .wr_en(wr_en), .st(st), .tx_dis(tx_dis), .rx_sqdis(rx_sqdis)
);

// File: tb/tb_twi_mgmt_slave.sv
module tb_twi_mgmt_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1, mod_sel_n = 1'b0;
  logic sda_oe, rd_stb, sda_bus;
  logic [3:0] tx_dis, rx_sqdis;
  logic [6:0] rd_addr;
  assign sda_bus = sda_m & ~sda_oe;

  twi_mgmt_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .mod_sel_n(mod_sel_n),
    .sda_oe(sda_oe), .tx_dis(tx_dis), .rx_sqdis(rx_sqdis),
    .rd_stb(rd_stb), .rd_addr(rd_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, stb_cnt = 0;
  logic [6:0] stb_addr = '0;
  logic done = 1'b0;

  always @(negedge clk) if (rd_stb) begin stb_cnt++; stb_addr = rd_addr; end

  // {page, pointer, data}
  localparam logic [23:0] VEC [8] = '{
    {8'd0, 8'h10, 8'hA5}, {8'd0, 8'h00, 8'h3C}, {8'd0, 8'h40, 8'hFF},
    {8'd0, 8'h7E, 8'h81}, {8'd1, 8'h80, 8'h11}, {8'd1, 8'hC3, 8'h5A},
    {8'd2, 8'h80, 8'h99}, {8'd3, 8'hFF, 8'h6E}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic bit_tx(input logic b);
    sda_m = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
  endtask
  task automatic bit_rx(output logic b);
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); b = sda_bus; wt(Q); scl = 1'b0; wt(Q);
  endtask
  task automatic cond_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask
  task automatic cond_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask
  task automatic byte_tx(input logic [7:0] b, output logic ok);
    logic a;
    for (int i = 7; i >= 0; i--) bit_tx(b[i]);
    bit_rx(a);
    ok = ~a;
  endtask
  task automatic byte_rx(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_rx(d[i]);
    bit_tx(last);
  endtask

  task automatic xfer_wr(input logic [6:0] dev, input logic [7:0] ptr,
                         input logic [31:0] d, input int n, output logic acked);
    logic a;
    cond_start();
    byte_tx({dev, 1'b0}, a);
    acked = a;
    if (a) begin
      byte_tx(ptr, a);
      for (int i = 0; i < n; i++) byte_tx(d[31-8*i -: 8], a);
    end
    cond_stop();
  endtask
  task automatic xfer_rd(input logic [7:0] ptr, input int n, output logic [31:0] d);
    logic a;
    logic [7:0] b;
    d = '0;
    cond_start();
    byte_tx({DEV, 1'b0}, a);
    byte_tx(ptr, a);
    cond_start();
    byte_tx({DEV, 1'b1}, a);
    for (int i = 0; i < n; i++) begin
      byte_rx(i == n-1, b);
      d[31-8*i -: 8] = b;
    end
    cond_stop();
  endtask
  task automatic wr1(input logic [7:0] ptr, input logic [7:0] v);
    logic a;
    xfer_wr(DEV, ptr, {v, 24'h0}, 1, a);
  endtask
  task automatic rd1(input logic [7:0] ptr, output logic [7:0] v);
    logic [31:0] d;
    xfer_rd(ptr, 1, d);
    v = d[31:24];
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0] v;
    logic [31:0] d;
    logic a;
    int c0;
    wt(4); rst = 1'b0; wt(4);
    // R9: reset state
    chk("R9 tx_dis after reset", 32'(tx_dis), 32'h0);
    chk("R9 rx_sqdis after reset", 32'(rx_sqdis), 32'h0);
    chk("R9 sda released after reset", 32'(sda_oe), 32'h0);

    // R3 R4 R5: table of page/pointer/data writes read back
    for (int k = 0; k < 8; k++) begin
      wr1(PAGE_SEL(k), VEC[k][23:16]);
      wr1(VEC[k][15:8], VEC[k][7:0]);
      rd1(VEC[k][15:8], v);
      chk("R3 R5 table readback", 32'(v), 32'(VEC[k][7:0]));
    end

    // R5: page isolation, R4: lower region independent of page
    wr1(8'd127, 8'd1);
    rd1(8'h80, v); chk("R5 page 1 keeps its byte", 32'(v), 32'h11);
    rd1(8'h10, v); chk("R4 lower byte under page 1", 32'(v), 32'hA5);
    wr1(8'd127, 8'h07);
    rd1(8'd127, v); chk("R5 page select readback", 32'(v), 32'h03);

    // R7: transmitter disable
    wr1(8'd86, 8'h0A);
    chk("R7 tx_dis from byte 86", 32'(tx_dis), 32'hA);
    rd1(8'd86, v); chk("R7 byte 86 readback", 32'(v), 32'h0A);

    // R8: squelch disable only in page 3
    wr1(8'd127, 8'd3); wr1(8'd240, 8'hF0);
    chk("R8 rx_sqdis from page 3 byte 240", 32'(rx_sqdis), 32'hF);
    wr1(8'd127, 8'd2); wr1(8'd240, 8'h30);
    chk("R8 page 2 byte 240 ignored", 32'(rx_sqdis), 32'hF);
    rd1(8'd240, v); chk("R8 page 2 byte 240 is plain storage", 32'(v), 32'h30);
    wr1(8'd127, 8'd3); wr1(8'd240, 8'h50);
    chk("R8 rx_sqdis lanes", 32'(rx_sqdis), 32'h5);

    // R1: foreign address
    xfer_wr(7'h51, 8'h10, 32'h0, 1, a);
    chk("R1 no ack for 0x51", 32'(a), 32'h0);
    rd1(8'h10, v); chk("R1 byte unchanged", 32'(v), 32'hA5);

    // R2: deselected
    mod_sel_n = 1'b1;
    xfer_wr(DEV, 8'h10, 32'h0, 1, a);
    mod_sel_n = 1'b0;
    chk("R2 no ack when deselected", 32'(a), 32'h0);
    rd1(8'h10, v); chk("R2 byte unchanged", 32'(v), 32'hA5);

    // R3: sequential burst
    xfer_wr(DEV, 8'h20, 32'h01020304, 4, a);
    xfer_rd(8'h20, 4, d);
    chk("R3 burst readback", d, 32'h01020304);

    // R6: wrap 255 -> 128 in page 1
    wr1(8'd127, 8'd1);
    xfer_wr(DEV, 8'hFE, 32'hD1D2D300, 3, a);
    rd1(8'h80, v); chk("R6 write wraps to 128", 32'(v), 32'hD3);
    xfer_rd(8'hFF, 2, d);
    chk("R6 read wraps to 128", d[31:16], 32'hD2D3);

    // R10: read strobes
    c0 = stb_cnt;
    rd1(8'h10, v);
    chk("R10 one strobe for lower read", 32'(stb_cnt - c0), 32'd1);
    chk("R10 strobe offset", 32'(stb_addr), 32'h10);
    c0 = stb_cnt;
    rd1(8'h80, v);
    chk("R10 no strobe for upper read", 32'(stb_cnt - c0), 32'd0);

    // R9: reset clears volatile controls
    @(negedge clk); rst = 1'b1; wt(3); rst = 1'b0; wt(4);
    chk("R9 tx_dis cleared", 32'(tx_dis), 32'h0);
    chk("R9 rx_sqdis cleared", 32'(rx_sqdis), 32'h0);
    rd1(8'd127, v); chk("R9 page select cleared", 32'(v), 32'h0);
    report();
  end

  function automatic logic [7:0] PAGE_SEL(input int k);
    return (k >= 0) ? 8'd127 : 8'd127;
  endfunction

endmodule